// File: doc/BRIEF.md
# DDR Input Gearbox (Two-Stream Deserialiser)

This block sits behind an external double-data-rate input register on a wide source-synchronous receive port. For every pin it is handed two bits on each rising edge of the fast interface clock: the bit that was launched with the rising edge and the bit that was launched with the falling edge. The rising-edge bits form one stream and the falling-edge bits form another. Each stream fills its own 4-bit shifter. After four fast cycles the two shifters are woven into one 8-bit word per pin.

That word is parked in a holding register when the fast-side beat counter wraps. It stays there, untouched, for four fast cycles. A core clock running at one quarter of the fast rate samples it once per core cycle, together with a flag that says a whole word has been assembled since reset. The default build carries 36 pins (32 data and 4 control) running at 312.5 Mb/s each, on a 156.25 MHz fast clock and a 39.0625 MHz core clock. Any search for the word boundary is left to logic further downstream. Alignment is fixed by reset: the first fast edge after reset is beat 0.

Top module: `ddr_in_gearbox`

## Requirements
- R1: Beat k of a word is the k-th fast rising edge of that word (k = 0..3). Beat 0 is the first fast edge with reset low. At beat k, the rising-edge input carries word bit 2k and the falling-edge input carries word bit 2k+1. The output word is therefore {odd3, even3, odd2, even2, odd1, even1, odd0, even0}.
- R2: Each pin is assembled on its own. Pin c's word occupies word_out[8c+7:8c] and depends only on rise_bits[c] and fall_bits[c].
- R3: Reset is synchronous and active high. While it is held, and after the first core edge that samples it, word_valid is 0 and word_out is all zeros. word_out stays zero for as long as word_valid is low.
- R4: No partial word is presented. word_valid stays low until a full four-beat word has been assembled, and the first valid word is the one whose beat 0 came on the first fast edge after reset. With the core clock rising half a fast period after a fast rising edge, and reset released on a core falling edge, exactly one core sample shows word_valid low before the first word appears.
- R5: Once word_valid rises it stays high on every core cycle. Each core cycle presents the next word in input order, with no word skipped or repeated, so latency is constant.
- R6: Asserting reset in the middle of a word discards that partial word. It also restarts alignment, so that the first fast edge after release is again beat 0 of the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Source-synchronous interface clock; both streams shift on its rising edge |
| core_clk | input | 1 | Core clock at one quarter of the fast rate; samples the holding registers |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| rise_bits | input | N_CH | Per pin, the bit captured on the rising edge (even stream) |
| fall_bits | input | N_CH | Per pin, the bit captured on the falling edge (odd stream) |
| word_out | output | N_CH*8 | Per-pin assembled word, pin c in bits 8c+7..8c |
| word_valid | output | 1 | High on every core cycle that carries a complete word |

## Verification
Each word is described by its even nibble and its odd nibble, and the expected byte is worked out by hand. The patterns include a single bit at each end, all even bits only, all odd bits only, and mixed nibbles. Together these show whether the streams are swapped, the beat order is reversed, or the weave is off by one position. Odd-numbered pins receive inverted nibbles, and each pin starts at a different row of the table. A lane cross-wire or shared state therefore shows up as a wrong byte on some pin rather than passing unnoticed. The stream runs back to back, and the first valid sample, any gap and the word order are all checked. This is then repeated after a reset that lands one beat into a word, which shows that alignment restarts and that the partial word is dropped.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

    // Default geometry: 32 data pins plus 4 control pins, 4 beats per word.
    localparam int unsigned GBX_DEF_CHANNELS = 36;
    localparam int unsigned GBX_DEF_BEATS    = 4;

    // Width of one assembled word for a given beat count (two bits per beat).
    function automatic int unsigned gbx_word_bits(input int unsigned beats);
        return 2 * beats;
    endfunction

    // Position inside the woven word of the bit taken at a given beat from
    // the even (rising) stream when odd_stream is 0, or from the odd
    // (falling) stream when odd_stream is 1.
    function automatic int unsigned gbx_slot(input int unsigned beat,
                                             input int unsigned odd_stream);
        return 2 * beat + odd_stream;
    endfunction

    // Counter width for a beat count of at least two.
    function automatic int unsigned gbx_cnt_bits(input int unsigned beats);
        return (beats <= 2) ? 1 : $clog2(beats);
    endfunction

endpackage

// File: rtl/gbx_beat_counter.sv
module gbx_beat_counter
    import gbx_pkg::*;
#(
    parameter int unsigned BEATS = GBX_DEF_BEATS
) (
    input  logic clk,
    input  logic rst,
    output logic beat_last,
    output logic word_seen
);
    localparam int unsigned CNT_W = gbx_cnt_bits(BEATS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] beat_q;
    logic             seen_q;

    assign beat_last = (beat_q == LAST);
    assign word_seen = seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            seen_q <= 1'b0;
        end else begin
            beat_q <= beat_last ? '0 : beat_q + 1'b1;
            if (beat_last) begin
                seen_q <= 1'b1;
            end
        end
    end

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
        beat_last |=> (beat_q == '0)); // R1
    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (rst)
        !beat_last |=> (beat_q == CNT_W'($past(beat_q) + 1'b1))); // R1
    AST_SEEN_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        beat_last |=> word_seen); // R4
    AST_NO_EARLY_SEEN: assert property (@(posedge clk) disable iff (rst)
        (!word_seen && !beat_last) |=> !word_seen); // R4

endmodule

// File: rtl/gbx_lane.sv
module gbx_lane
    import gbx_pkg::*;
#(
    parameter int unsigned BEATS = GBX_DEF_BEATS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            beat_last,
    input  logic                            rise_bit,
    input  logic                            fall_bit,
    output logic [gbx_word_bits(BEATS)-1:0] hold_word
);
    localparam int unsigned WORD_W = gbx_word_bits(BEATS);

    logic [BEATS-1:0]  even_q, odd_q;
    logic [BEATS-1:0]  even_d, odd_d;
    logic [WORD_W-1:0] woven;
    logic [WORD_W-1:0] hold_q;

    // New bits enter at the top so the oldest (beat 0) ends at index 0.
    assign even_d = {rise_bit, even_q[BEATS-1:1]};
    assign odd_d  = {fall_bit, odd_q[BEATS-1:1]};

    for (genvar b = 0; b < BEATS; b++) begin : g_weave
        assign woven[gbx_slot(b, 0)] = even_d[b];
        assign woven[gbx_slot(b, 1)] = odd_d[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            even_q <= '0;
            odd_q  <= '0;
            hold_q <= '0;
        end else begin
            even_q <= even_d;
            odd_q  <= odd_d;
            if (beat_last) begin
                hold_q <= woven;
            end
        end
    end

    assign hold_word = hold_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        !beat_last |=> $stable(hold_word)); // R5
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hold_word == '0)); // R3

endmodule

// File: rtl/gbx_core_capture.sv
module gbx_core_capture #(
    parameter int unsigned WIDTH = 288
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             seen_in,
    input  logic [WIDTH-1:0] data_in,
    output logic [WIDTH-1:0] data_out,
    output logic             valid_out
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_out  <= '0;
            valid_out <= 1'b0;
        end else begin
            data_out  <= data_in;
            valid_out <= seen_in;
        end
    end

    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
        valid_out |=> valid_out); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !valid_out |-> (data_out == '0)); // R3

endmodule

// File: rtl/ddr_in_gearbox.sv
module ddr_in_gearbox
    import gbx_pkg::*;
#(
    parameter int unsigned N_CH  = GBX_DEF_CHANNELS,
    parameter int unsigned BEATS = GBX_DEF_BEATS
) (
    input  logic                                 fast_clk,
    input  logic                                 core_clk,
    input  logic                                 rst,
    input  logic [N_CH-1:0]                      rise_bits,
    input  logic [N_CH-1:0]                      fall_bits,
    output logic [N_CH*gbx_word_bits(BEATS)-1:0] word_out,
    output logic                                 word_valid
);
    localparam int unsigned WORD_W = gbx_word_bits(BEATS);
    localparam int unsigned BUS_W  = N_CH * WORD_W;

    logic             beat_last;
    logic             word_seen;
    logic [BUS_W-1:0] hold_bus;

    gbx_beat_counter #(.BEATS(BEATS)) u_beat (
        .clk       (fast_clk),
        .rst       (rst),
        .beat_last (beat_last),
        .word_seen (word_seen)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        gbx_lane #(.BEATS(BEATS)) u_lane (
            .clk       (fast_clk),
            .rst       (rst),
            .beat_last (beat_last),
            .rise_bit  (rise_bits[c]),
            .fall_bit  (fall_bits[c]),
            .hold_word (hold_bus[c*WORD_W +: WORD_W])
        );
    end

    gbx_core_capture #(.WIDTH(BUS_W)) u_cap (
        .clk       (core_clk),
        .rst       (rst),
        .seen_in   (word_seen),
        .data_in   (hold_bus),
        .data_out  (word_out),
        .valid_out (word_valid)
    );

endmodule

// File: tb/ddr_in_gearbox_test.sv
module ddr_in_gearbox_test;

    localparam int N_CH  = 36;
    localparam int NVEC  = 12;

    typedef struct packed {
        logic [3:0] even;
        logic [3:0] odd;
        logic [7:0] word;
    } vec_t;

    // even nibble bit j = rising bit of beat j, odd nibble bit j = falling bit
    // of beat j; word is the hand-worked expected byte (R1).
    localparam vec_t VEC [NVEC] = '{
        '{4'hF, 4'h0, 8'h55},
        '{4'h0, 4'hF, 8'hAA},
        '{4'h1, 4'h0, 8'h01},
        '{4'h0, 4'h8, 8'h80},
        '{4'h0, 4'h0, 8'h00},
        '{4'hF, 4'hF, 8'hFF},
        '{4'h3, 4'h0, 8'h05},
        '{4'h0, 4'hC, 8'hA0},
        '{4'h5, 4'h0, 8'h11},
        '{4'hA, 4'h5, 8'h66},
        '{4'h9, 4'h6, 8'h69},
        '{4'h2, 4'h4, 8'h24}
    };

    logic                fast_clk = 1'b0;
    logic                core_clk = 1'b0;
    logic                rst = 1'b1;
    logic [N_CH-1:0]     rise_bits = '0;
    logic [N_CH-1:0]     fall_bits = '0;
    logic [N_CH*8-1:0]   word_out;
    logic                word_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    ddr_in_gearbox #(.N_CH(N_CH), .BEATS(4)) uut (
        .fast_clk   (fast_clk),
        .core_clk   (core_clk),
        .rst        (rst),
        .rise_bits  (rise_bits),
        .fall_bits  (fall_bits),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    // 100 MHz fast clock; core clock at a quarter rate, rising half a fast
    // period after a fast rising edge.
    always #5 fast_clk = ~fast_clk;
    initial begin
        #10;
        forever begin
            core_clk = 1'b1; #20;
            core_clk = 1'b0; #20;
        end
    end

    function automatic vec_t pick(input int frame, input int ch);
        vec_t v;
        v = VEC[(frame + ch) % NVEC];
        if (ch % 2 == 1) begin
            v.even = ~v.even;
            v.odd  = ~v.odd;
            v.word = ~v.word;
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int base, input int nframes);
        for (int f = 0; f < nframes; f++) begin
            for (int j = 0; j < 4; j++) begin
                for (int c = 0; c < N_CH; c++) begin
                    vec_t v;
                    v = pick(base + f, c);
                    rise_bits[c] = v.even[j];
                    fall_bits[c] = v.odd[j];
                end
                @(negedge fast_clk);
            end
        end
        rise_bits = '0;
        fall_bits = '0;
    endtask

    task automatic monitor(input int base, input int samples, input string tag);
        int pre = 0;
        int got = 0;
        bit started = 0;
        for (int s = 0; s < samples; s++) begin
            @(negedge core_clk);
            if (!word_valid) begin
                if (started) check(0, {tag, " R5 gap in word_valid"}, 0, 1);
                else pre++;
            end else begin
                int bad_ch = -1;
                int act_b = 0;
                int exp_b = 0;
                if (!started) begin
                    started = 1;
                    check(pre == 1, {tag, " R4 low samples before first word"}, pre, 1);
                end
                for (int c = 0; c < N_CH; c++) begin
                    vec_t v;
                    v = pick(base + got, c);
                    if (word_out[c*8 +: 8] !== v.word && bad_ch < 0) begin
                        bad_ch = c;
                        act_b = int'(word_out[c*8 +: 8]);
                        exp_b = int'(v.word);
                    end
                end
                check(bad_ch < 0, {tag, " R1,R2,R5 word order and content"}, act_b, exp_b);
                got++;
            end
        end
        check(got == samples - 1, {tag, " R5 words received"}, got, samples - 1);
    endtask

    initial begin
        // Reset state (R3)
        repeat (3) @(negedge core_clk);
        check(word_valid == 1'b0, "R3 valid low in reset", int'(word_valid), 0);
        check(word_out == '0, "R3 word zero in reset", int'(word_out[31:0]), 0);

        // Table walk: release on a core falling edge, beat 0 on next fast edge
        rst = 1'b0;
        fork
            drive(0, NVEC + 2);
            monitor(0, NVEC + 1, "table");
        join

        // Mid-word reset (R6): one beat of a new word, then reset
        for (int c = 0; c < N_CH; c++) begin
            rise_bits[c] = 1'b1;
            fall_bits[c] = 1'b0;
        end
        @(negedge fast_clk);
        rst = 1'b1;
        rise_bits = '0;
        repeat (3) @(negedge core_clk);
        check(word_valid == 1'b0, "R3,R6 valid low after mid-word reset", int'(word_valid), 0);
        check(word_out == '0, "R3,R6 word zero after mid-word reset", int'(word_out[31:0]), 0);

        rst = 1'b0;
        fork
            drive(5, 8);
            monitor(5, 7, "R6 realign");
        join

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog: actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule